// File: doc/BRIEF.md
# Parallel Flash Control Front End

This block is the control and bus-interface logic of an asynchronous parallel NOR-style flash device, modelled as synchronous logic. It decodes three chip-select inputs, an active-low output enable, an active-low write strobe and an active-low reset/power-down pin. From these it produces a data output with a separate drive enable, standing in for tri-state pins. It also keeps a read mode, an 8-bit status register and a ready/busy pin. Commands are accepted on the rising edge of the write strobe.

Reads in array mode go through a page buffer of four 16-bit words. A read that stays inside the buffered page returns the new word one cycle later. A read of another page fetches the whole page from a simple array port with a fixed latency. Erase and program are reduced to a busy timer. That timer keeps running while the device is deselected and stops when the reset pin is pulled low.

Top module: `pflash_ctrl`

## Requirements
- R1: With `ce_i` = {sel2, sel1, sel0}, the device is enabled for 3'b000, 3'b100, 3'b101 and 3'b110 and disabled for the other four values. With sel2 and sel1 held low, sel0 alone selects the device.
- R2: `dq_oe_o` is 1 one cycle after a cycle in which the device is enabled, `oe_ni`=0, `we_ni`=1 and the wake-up count has expired. In every other case it is 0, and a disabled device has it at 0 whatever `oe_ni` is.
- R3: A command is taken from `dq_i[7:0]` on the rising edge of `we_ni` while the device is enabled. 0xFF selects array reads, 0x70 selects status reads and 0x90 selects identifier reads. In identifier mode, word offset 0 reads MFR_ID, offset 1 reads DEV_ID and any other offset reads 0.
- R4: A status read returns {8'h00, status}. Status bit 7 is 1 when ready, and the register holds 0x80 after power-up.
- R5: The pair 0x20, 0xD0 starts an erase that is busy for ERASE_CYC cycles. 0x20 followed by any other value sets status bits 5 and 4 (giving 0xB0). 0x50 clears those two bits. Each of these selects status reads.
- R6: 0x40 followed by any data word starts a program that is busy for PROG_CYC cycles and selects status reads. Commands written while busy are ignored.
- R7: `sts_o` is 0 while an operation is busy or a reset sequence is in progress, and 1 otherwise. Status bit 7 is 0 while busy.
- R8: Deselecting the device during an operation does not stop it. `sts_o` returns to 1 after ERASE_CYC or PROG_CYC cycles as usual.
- R9: `rp_ni`=0 aborts any operation and drives `sts_o` low at once. It selects array reads, reloads status with 0x80 and discards the buffered page.
- R10: A reset pulse is stretched to at least RP_MIN cycles. After it, reads stay suppressed for WAKE_CYC cycles and commands are ignored for RECOV_CYC cycles. `sts_o` stays 0 until the commands are accepted again.
- R11: In array mode, a read whose page is already buffered returns the addressed word on `dq_o` at the next clock edge, without an array access.
- R12: A read of a page that is not buffered raises `arr_rd_o` for one cycle, with the page number (`addr_i` without its two low bits) on `arr_page_o`. `arr_rdata_i` is captured ARR_LAT edges later, and the word appears on `dq_o` one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| ce_i | input | 3 | Chip selects {sel2, sel1, sel0} |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low; command taken on its rising edge |
| rp_ni | input | 1 | Reset/power-down pin, active low |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | DATA_W | Command and data input |
| dq_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | Data drive enable (0 means high impedance) |
| sts_o | output | 1 | Ready (1) / busy (0) |
| arr_rd_o | output | 1 | Array page fetch pulse |
| arr_page_o | output | ADDR_W-2 | Page number of the fetch |
| arr_rdata_i | input | 4*DATA_W | Page data from the array, word 0 in the low bits |

## Verification
The hardest state to reach is a reset pulse that is shorter than RP_MIN, or that lands in the middle of an operation. Reaching it needs a command sequence that has already started the busy timer, and then `rp_ni` dropped at a known cycle. The bench runs an erase, pulls `rp_ni` low partway through, and then reads the reset status and a freshly fetched page. A separate single-cycle pulse is timed edge by edge so that `sts_o` can be checked on each side of the stretched recovery window. A command written inside that window is shown to be ignored, because the next read returns array data.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_STATUS, MODE_IDENT} rd_mode_e;
  typedef enum logic [1:0] {PEND_NONE, PEND_ERASE, PEND_PROG} pend_e;

  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS = 8'h70;
  localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ERASE_SET = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [7:0] CMD_PROG_SET  = 8'h40;
  localparam logic [7:0] CMD_CLR_STAT  = 8'h50;

  // ce = {sel2, sel1, sel0}; decode is not monotonic
  function automatic logic ce_enabled(input logic [2:0] ce);
    case (ce)
      3'b000, 3'b100, 3'b101, 3'b110: return 1'b1;
      default:                        return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pflash_rst_seq.sv
module pflash_rst_seq #(
  parameter int RP_MIN    = 3,
  parameter int WAKE_CYC  = 5,
  parameter int RECOV_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rp_ni,
  output logic hold_o,
  output logic wake_o,
  output logic cmd_ok_o
);
  localparam int UP_MAX = (WAKE_CYC > RECOV_CYC) ? WAKE_CYC : RECOV_CYC;
  localparam int LW     = $clog2(RP_MIN + 1);
  localparam int UW     = $clog2(UP_MAX + 1);

  logic [LW-1:0] low_cnt;
  logic [UW-1:0] up_cnt;
  logic          low_short;

  assign low_short = low_cnt < LW'(RP_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= LW'(RP_MIN);
      up_cnt  <= UW'(UP_MAX);
    end else if (!rp_ni) begin
      up_cnt <= '0;
      if (up_cnt != '0)   low_cnt <= LW'(1);   // new pulse
      else if (low_short) low_cnt <= low_cnt + 1'b1;
    end else if (low_short) begin
      low_cnt <= low_cnt + 1'b1;               // stretch short pulse
    end else if (up_cnt < UW'(UP_MAX)) begin
      up_cnt <= up_cnt + 1'b1;
    end
  end

  assign hold_o   = !rp_ni || low_short;
  assign wake_o   = !hold_o && (up_cnt >= UW'(WAKE_CYC));
  assign cmd_ok_o = !hold_o && (up_cnt >= UW'(RECOV_CYC));
endmodule

// File: rtl/pflash_cmd.sv
module pflash_cmd import pflash_pkg::*; #(
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output rd_mode_e   mode_o,
  output logic [7:0] status_o,
  output logic       busy_o,
  output logic       start_o
);
  localparam int BMAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int BW   = $clog2(BMAX + 1);

  rd_mode_e      mode_q;
  pend_e         pend_q;
  logic [1:0]    err_q;
  logic          busy_q;
  logic [BW-1:0] cnt_q;
  logic          wr_ok;

  assign wr_ok   = wr_i && !busy_q && !hold_i;
  assign start_o = wr_ok && ((pend_q == PEND_PROG) ||
                   (pend_q == PEND_ERASE && wdata_i == CMD_ERASE_GO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      pend_q <= PEND_NONE;
      err_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (hold_i) begin
      mode_q <= MODE_ARRAY;
      pend_q <= PEND_NONE;
      err_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (wr_ok) begin
      if (pend_q == PEND_ERASE) begin
        pend_q <= PEND_NONE;
        mode_q <= MODE_STATUS;
        if (wdata_i == CMD_ERASE_GO) begin
          busy_q <= 1'b1;
          cnt_q  <= BW'(ERASE_CYC - 1);
        end else begin
          err_q <= 2'b11;
        end
      end else if (pend_q == PEND_PROG) begin
        pend_q <= PEND_NONE;
        mode_q <= MODE_STATUS;
        busy_q <= 1'b1;
        cnt_q  <= BW'(PROG_CYC - 1);
      end else begin
        case (wdata_i)
          CMD_RD_ARRAY:  mode_q <= MODE_ARRAY;
          CMD_RD_STATUS: mode_q <= MODE_STATUS;
          CMD_RD_IDENT:  mode_q <= MODE_IDENT;
          CMD_CLR_STAT:  begin err_q <= '0; mode_q <= MODE_STATUS; end
          CMD_ERASE_SET: begin pend_q <= PEND_ERASE; mode_q <= MODE_STATUS; end
          CMD_PROG_SET:  begin pend_q <= PEND_PROG;  mode_q <= MODE_STATUS; end
          default: ;
        endcase
      end
    end
  end

  assign mode_o   = mode_q;
  assign busy_o   = busy_q;
  assign status_o = {!busy_q, 1'b0, err_q, 4'b0000};
endmodule

// File: rtl/pflash_page_buf.sv
module pflash_page_buf #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  parameter int ARR_LAT    = 4,
  localparam int OFS_W     = $clog2(PAGE_WORDS),
  localparam int TAG_W     = ADDR_W - OFS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         want_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         hit_o,
  output logic [DATA_W-1:0]            word_o,
  output logic                         arr_rd_o,
  output logic [TAG_W-1:0]             arr_page_o,
  input  logic [PAGE_WORDS*DATA_W-1:0] arr_rdata_i
);
  localparam int LW = $clog2(ARR_LAT + 1);

  logic [DATA_W-1:0] page_q [PAGE_WORDS];
  logic [TAG_W-1:0]  tag_q, ftag_q;
  logic              valid_q, fetch_q, rd_q;
  logic [LW-1:0]     fcnt_q;
  logic              load;

  assign hit_o = valid_q && (tag_q == addr_i[ADDR_W-1:OFS_W]);
  assign load  = fetch_q && (fcnt_q == '0) && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fetch_q <= 1'b0;
      rd_q    <= 1'b0;
      fcnt_q  <= '0;
      tag_q   <= '0;
      ftag_q  <= '0;
    end else begin
      rd_q <= 1'b0;
      if (flush_i) begin
        valid_q <= 1'b0;
        fetch_q <= 1'b0;
      end else if (fetch_q) begin
        if (fcnt_q == '0) begin
          fetch_q <= 1'b0;
          valid_q <= 1'b1;
          tag_q   <= ftag_q;
        end else begin
          fcnt_q <= fcnt_q - 1'b1;
        end
      end else if (want_i && !hit_o) begin
        fetch_q <= 1'b1;
        rd_q    <= 1'b1;
        ftag_q  <= addr_i[ADDR_W-1:OFS_W];
        fcnt_q  <= LW'(ARR_LAT - 1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      for (int i = 0; i < PAGE_WORDS; i++)
        page_q[i] <= arr_rdata_i[i*DATA_W +: DATA_W];
    end
  end

  assign word_o     = page_q[addr_i[OFS_W-1:0]];
  assign arr_rd_o   = rd_q;
  assign arr_page_o = ftag_q;
endmodule

// File: rtl/pflash_ctrl.sv
module pflash_ctrl import pflash_pkg::*; #(
  parameter int          ADDR_W     = 22,
  parameter int          DATA_W     = 16,
  parameter int          PAGE_WORDS = 4,
  parameter int          ARR_LAT    = 4,
  parameter int          ERASE_CYC  = 40,
  parameter int          PROG_CYC   = 12,
  parameter int          RP_MIN     = 3,
  parameter int          WAKE_CYC   = 5,
  parameter int          RECOV_CYC  = 7,
  parameter logic [15:0] MFR_ID     = 16'h00A5,
  parameter logic [15:0] DEV_ID     = 16'h0017,
  localparam int         OFS_W      = $clog2(PAGE_WORDS),
  localparam int         TAG_W      = ADDR_W - OFS_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [2:0]                   ce_i,
  input  logic                         oe_ni,
  input  logic                         we_ni,
  input  logic                         rp_ni,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            dq_i,
  output logic [DATA_W-1:0]            dq_o,
  output logic                         dq_oe_o,
  output logic                         sts_o,
  output logic                         arr_rd_o,
  output logic [TAG_W-1:0]             arr_page_o,
  input  logic [PAGE_WORDS*DATA_W-1:0] arr_rdata_i
);
  logic              hold, wake, cmd_ok, busy, hit, start;
  logic              dev_en, we_q, cmd_wr, rd_act, want;
  rd_mode_e          mode;
  logic [7:0]        status;
  logic [DATA_W-1:0] page_word, rd_word, dq_q;
  logic              dq_oe_q;
  logic              unused_dq_hi;

  assign unused_dq_hi = ^dq_i[DATA_W-1:8];
  assign dev_en = ce_enabled(ce_i);
  assign cmd_wr = dev_en && we_ni && !we_q && cmd_ok;
  assign rd_act = dev_en && !oe_ni && we_ni && wake;
  assign want   = rd_act && (mode == MODE_ARRAY);

  pflash_rst_seq #(.RP_MIN(RP_MIN), .WAKE_CYC(WAKE_CYC), .RECOV_CYC(RECOV_CYC)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rp_ni(rp_ni),
    .hold_o(hold), .wake_o(wake), .cmd_ok_o(cmd_ok)
  );

  pflash_cmd #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .wr_i(cmd_wr),
    .wdata_i(dq_i[7:0]), .mode_o(mode), .status_o(status),
    .busy_o(busy), .start_o(start)
  );

  pflash_page_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS),
                    .ARR_LAT(ARR_LAT)) u_page (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(hold || start), .want_i(want),
    .addr_i(addr_i), .hit_o(hit), .word_o(page_word),
    .arr_rd_o(arr_rd_o), .arr_page_o(arr_page_o), .arr_rdata_i(arr_rdata_i)
  );

  always_comb begin
    case (mode)
      MODE_STATUS: rd_word = {{(DATA_W-8){1'b0}}, status};
      MODE_IDENT: begin
        if (addr_i[OFS_W-1:0] == OFS_W'(0))      rd_word = DATA_W'(MFR_ID);
        else if (addr_i[OFS_W-1:0] == OFS_W'(1)) rd_word = DATA_W'(DEV_ID);
        else                                     rd_word = '0;
      end
      default: rd_word = page_word;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b1;
      dq_q    <= '0;
      dq_oe_q <= 1'b0;
    end else begin
      we_q    <= we_ni;
      dq_oe_q <= rd_act;
      if (rd_act && (mode != MODE_ARRAY || hit)) dq_q <= rd_word;
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = dq_oe_q;
  assign sts_o   = !busy && cmd_ok;
endmodule

// File: rtl/pflash_ctrl_chk.sv
module pflash_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] ce_i,
  input logic       oe_ni,
  input logic       we_ni,
  input logic       rp_ni,
  input logic       dq_oe_o,
  input logic       sts_o,
  input logic       arr_rd_o
);
  logic sel;
  assign sel = (ce_i == 3'b000) || (ce_i[2] && !(ce_i[1] && ce_i[0]));

  // R2
  oe_high_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |=> !dq_oe_o);
  // R1
  desel_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel |=> !dq_oe_o);
  // R2
  we_low_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |=> !dq_oe_o);
  // R9
  rp_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_ni |-> !sts_o);
  // R10
  rp_rise_nodrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rp_ni) |=> !dq_oe_o);
  // R10
  rp_rise_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rp_ni) |-> !sts_o);
  // R12
  fetch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_rd_o |=> !arr_rd_o);
endmodule

bind pflash_ctrl pflash_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .oe_ni(oe_ni), .we_ni(we_ni),
  .rp_ni(rp_ni), .dq_oe_o(dq_oe_o), .sts_o(sts_o), .arr_rd_o(arr_rd_o)
);

// File: tb/pflash_ctrl_tb_top.sv
`timescale 1ns/1ps
module pflash_ctrl_tb_top;
  localparam int ADDR_W = 22;
  localparam int ARR_LAT = 4;
  localparam int ERASE_CYC = 40;
  localparam int PROG_CYC = 12;
  localparam int TAG_W = ADDR_W - 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] ce_i = 3'b111;
  logic oe_ni = 1'b1, we_ni = 1'b1, rp_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic dq_oe_o, sts_o, arr_rd_o;
  logic [TAG_W-1:0] arr_page_o;
  logic [63:0] arr_rdata_i;

  int n_chk = 0, n_bad = 0, n_fetch = 0;

  always #2 clk = ~clk;

  pflash_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .oe_ni(oe_ni), .we_ni(we_ni),
    .rp_ni(rp_ni), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .sts_o(sts_o), .arr_rd_o(arr_rd_o), .arr_page_o(arr_page_o),
    .arr_rdata_i(arr_rdata_i)
  );

  function automatic logic [15:0] mkword(input logic [TAG_W-1:0] pg, input int idx);
    return {pg[9:0], 4'hC, 2'(idx)};
  endfunction

  always_comb
    for (int i = 0; i < 4; i++) arr_rdata_i[i*16 +: 16] = mkword(arr_page_o, i);

  always @(posedge clk) if (arr_rd_o) n_fetch++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    ce_i = 3'b000; oe_ni = 1'b1; dq_i = d; we_ni = 1'b0;
    step(1);
    we_ni = 1'b1;
    step(1);
  endtask

  // {ce[2:0], oe_n, we_n, expected dq_oe}
  localparam logic [5:0] VEC [14] = '{
    6'b000_01_1, 6'b001_01_0, 6'b010_01_0, 6'b011_01_0,
    6'b100_01_1, 6'b101_01_1, 6'b110_01_1, 6'b111_01_0,
    6'b000_11_0, 6'b100_11_0, 6'b000_00_0, 6'b110_00_0,
    6'b011_11_0, 6'b001_00_0
  };

  initial begin
    #(4 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0;
    step(3);
    rst_ni = 1'b1;
    step(2);
    // reset state
    chk("R2 reset drive", 16'(dq_oe_o), 16'h0);
    chk("R7 reset ready", 16'(sts_o), 16'h1);
    chk("R12 no fetch", 16'(arr_rd_o), 16'h0);

    wr(16'h0070);
    oe_ni = 1'b0; step(2);
    chk("R4 status after power-up", dq_o, 16'h0080);

    // decode / drive table (dq_i = 0x70 keeps any stray command harmless)
    for (int v = 0; v < 14; v++) begin
      ce_i = VEC[v][5:3]; oe_ni = VEC[v][2]; we_ni = VEC[v][1];
      step(2);
      chk($sformatf("R1/R2 vec %0d", v), 16'(dq_oe_o), 16'(VEC[v][0]));
    end
    ce_i = 3'b000; oe_ni = 1'b1; we_ni = 1'b1; step(1);

    // R3 identifier
    wr(16'h0090);
    addr_i = 22'd0; oe_ni = 1'b0; step(2);
    chk("R3 ident 0", dq_o, 16'h00A5);
    addr_i = 22'd1; step(2);
    chk("R3 ident 1", dq_o, 16'h0017);
    addr_i = 22'd2; step(2);
    chk("R3 ident 2", dq_o, 16'h0000);

    // R12 page miss latency
    wr(16'h00FF);
    f0 = n_fetch;
    addr_i = 22'h000104; oe_ni = 1'b0;
    step(1);
    chk("R12 fetch pulse", 16'(arr_rd_o), 16'h1);
    chk("R12 fetch page", 16'(arr_page_o), 16'h0041);
    step(ARR_LAT);
    chk("R12 not yet", dq_o, 16'h0000);
    step(1);
    chk("R12 miss data", dq_o, mkword(20'h41, 0));
    // R11 page hits
    addr_i = 22'h000106; step(1);
    chk("R11 hit 2", dq_o, mkword(20'h41, 2));
    addr_i = 22'h000107; step(1);
    chk("R11 hit 3", dq_o, mkword(20'h41, 3));
    chk("R11 one fetch", 16'(n_fetch - f0), 16'h1);
    addr_i = 22'h0002A3; step(ARR_LAT + 2);
    chk("R12 second page", dq_o, mkword(20'hA8, 3));

    // R5/R8 erase while deselected
    wr(16'h0020); wr(16'h00D0);
    chk("R7 busy sts", 16'(sts_o), 16'h0);
    ce_i = 3'b111; oe_ni = 1'b0;
    step(ERASE_CYC - 2);
    chk("R8 still busy", 16'(sts_o), 16'h0);
    chk("R8 deselect hiz", 16'(dq_oe_o), 16'h0);
    step(3);
    chk("R8 done on time", 16'(sts_o), 16'h1);

    // R6 program, command during busy ignored
    wr(16'h0040); wr(16'h1234);
    wr(16'h00FF);
    oe_ni = 1'b0; step(2);
    chk("R7 status busy", dq_o, 16'h0000);
    step(PROG_CYC);
    chk("R6 FF ignored", dq_o, 16'h0080);

    // R5 sequence error and clear
    wr(16'h0020); wr(16'h0033);
    oe_ni = 1'b0; step(2);
    chk("R5 seq error", dq_o, 16'h00B0);
    wr(16'h0050);
    oe_ni = 1'b0; step(2);
    chk("R5 clear", dq_o, 16'h0080);

    // R9 abort an erase
    wr(16'h0020); wr(16'h00D0);
    step(3);
    rp_ni = 1'b0; step(1);
    chk("R9 sts low", 16'(sts_o), 16'h0);
    oe_ni = 1'b0; step(5);
    rp_ni = 1'b1; step(2);
    chk("R10 wake hiz", 16'(dq_oe_o), 16'h0);
    step(15);
    chk("R9 ready after", 16'(sts_o), 16'h1);
    chk("R9 array mode", dq_o, mkword(20'hA8, 3));
    wr(16'h0070);
    oe_ni = 1'b0; step(2);
    chk("R9 status reload", dq_o, 16'h0080);

    // R10 stretched short pulse
    oe_ni = 1'b1;
    rp_ni = 1'b0; step(1); rp_ni = 1'b1;
    step(8);
    chk("R10 recovery busy", 16'(sts_o), 16'h0);
    step(2);
    chk("R10 recovered", 16'(sts_o), 16'h1);
    // command in recovery ignored
    rp_ni = 1'b0; step(1); rp_ni = 1'b1;
    wr(16'h0070);
    step(10);
    oe_ni = 1'b0; step(ARR_LAT + 3);
    chk("R10 cmd ignored", dq_o, mkword(20'hA8, 3));

    // R1 sel0 alone
    ce_i = 3'b001; step(2);
    chk("R1 sel0 high", 16'(dq_oe_o), 16'h0);
    ce_i = 3'b000; step(2);
    chk("R1 sel0 low", 16'(dq_oe_o), 16'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule